// File: doc/BRIEF.md
# Decimal-Mode Accumulator Arithmetic Unit

This unit performs the arithmetic of an 8-bit accumulator processor in either plain binary or packed BCD (two decimal digits per byte). The caller presents an operation code, a destination code, two operands, the incoming carry, an immediate-operand marker and the decimal-mode flag, and pulses `start`. The unit raises `busy`, and after a fixed number of cycles it pulses `done` with a 16-bit result and the carry, zero, negative and half-carry flags. Those outputs then stay put until the next accepted start.

Decimal mode covers add, add-with-carry, subtract, subtract-with-borrow, negate and multiply. It applies only when the destination is one of the two byte accumulators or the 16-bit pair made from them. Any other destination always gets binary arithmetic. Subtraction and negation in decimal form give a ten's-complement result. Multiplication builds its product one multiplier digit at a time from repeated BCD additions of the multiplicand.

Top module: `dec_alu`

## Requirements
- R1: Encodings are op 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 negate (0 minus `opa`), 5 multiply, with 6 and 7 acting as add; dest 0 and 1 are the byte accumulators, 2 the 16-bit pair, 3 any other register. In binary, C is the carry out of the operation width (a borrow for subtract and negate), H is the carry out of bit 3 (a borrow into bit 3 for subtract and negate), Z is set when the result is zero, and N is its top bit. `carry_in` is used only by ops 1 and 3.
- R2: With decimal mode in effect, add and add-with-carry give the packed-BCD sum with each digit corrected. C is the decimal carry out of the top digit and H is the carry out of the low digit.
- R3: With decimal mode in effect, subtract and subtract-with-borrow give the ten's-complement BCD difference. C is set when a borrow leaves the top digit, and H when the low digit borrows.
- R4: With decimal mode in effect, negate gives the ten's complement of `opa` (zero for zero), with C set for any nonzero operand.
- R5: Destination 3 always uses binary arithmetic and binary timing, whatever the state of `dec_mode`.
- R6: Destinations 0 and 1 work on the low 8 bits only. The upper result byte reads zero, and C, Z and N refer to the 8-bit result. Destinations 2 and 3 work on all 16 bits.
- R7: Operations other than multiply pulse `done` 1 cycle after the start edge. A decimal operation marked immediate takes 2 cycles.
- R8: Binary multiply returns `opa[7:0]*opb[7:0]` as 16 bits after 12 cycles, with C and H cleared.
- R9: Decimal multiply returns the 4-digit BCD product of the two 2-digit BCD bytes after 17 cycles, with C and H cleared.
- R10: A start while `busy` is high is ignored and does not change the operation in flight.
- R11: `busy` is high from the start edge until `done`. `done` is a one-cycle pulse. Result and flags change only when `done` rises and hold until the next accepted start.
- R12: Reset clears `busy`, `done`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | Operation code |
| dest | input | 2 | Destination code selecting width and decimal eligibility |
| imm | input | 1 | Operand came from an immediate field |
| dec_mode | input | 1 | Decimal-mode flag from the condition codes |
| carry_in | input | 1 | Incoming carry or borrow |
| opa | input | 16 | First operand (negated operand for op 4) |
| opb | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Registered result |
| flag_c | output | 1 | Carry or borrow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative (top bit of result) |
| flag_h | output | 1 | Low-digit carry or borrow |

## Verification
The embedded assertions check the following on every cycle:
- the handshake: `done` is a lone pulse that never coincides with `busy`, and both are idle after reset;
- that latched operands cannot move while a start is ignored;
- that the result register is frozen whenever no operation is finishing;
- that byte-wide results keep a clear upper byte;
- that the decimal multiplier digit counters only count down.

Only the bench scenarios can show the arithmetic itself: digit correction, ten's-complement borrows, the decimal-versus-binary choice by destination, product values, and the exact cycle on which each kind of operation completes. These come from a behavioural model that compares against the unit every cycle.

// File: rtl/dec_alu_pkg.sv
package dec_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBC  = 3'd3,
    OP_NEG  = 3'd4,
    OP_MUL  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_ACC0 = 2'd0,
    DST_ACC1 = 2'd1,
    DST_PAIR = 2'd2,
    DST_OTHR = 2'd3
  } alu_dst_e;

  // One decimal digit position: returns {digit_carry, corrected_digit}
  function automatic logic [4:0] bcd_digit_add(logic [3:0] x, logic [3:0] y, logic ci);
    logic [4:0] s;
    s = {1'b0, x} + {1'b0, y} + {4'b0, ci};
    if (s > 5'd9) return {1'b1, 4'(s[3:0] + 4'd6)};
    else          return {1'b0, s[3:0]};
  endfunction

endpackage

// File: rtl/dec_alu_seq.sv
module dec_alu_seq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] lat,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic          fin
);
  logic [CW-1:0] cnt;

  assign accept = start && !busy;
  assign fin    = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= fin;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= lat;
      end else if (fin) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R12
  rst_idle_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!busy && !done));
  // R7
  lat_nonzero_chk: assert property (@(posedge clk) disable iff (rst) accept |-> (lat != '0));

endmodule

// File: rtl/dec_alu_addsub.sv
module dec_alu_addsub
  import dec_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          dec,
  input  logic          wide,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          h_out
);
  localparam int NDIG = DW / 4;
  localparam int NNDIG = NW / 4;
  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic          cy0;
  logic [DW-1:0] bx, am, bm, dres;
  logic [DW:0]   bsum;
  logic [4:0]    nib;
  logic [NDIG:0] dch;
  logic          raw_c, raw_h;
  logic [DW-1:0] raw_r;

  always_comb begin
    // a pending borrow becomes a missing carry in complement arithmetic
    cy0  = sub ? ~cin : cin;
    bx   = sub ? ~b : b;
    am   = wide ? a  : (a & NMASK);
    bm   = wide ? bx : (bx & NMASK);
    bsum = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, cy0};
    nib  = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'b0, cy0};

    dch[0] = cy0;
    dres   = '0;
    for (int i = 0; i < NDIG; i++) begin
      logic [3:0] dy;
      logic [4:0] t;
      dy = sub ? (4'd9 - b[4*i +: 4]) : b[4*i +: 4];
      t  = bcd_digit_add(a[4*i +: 4], dy, dch[i]);
      dres[4*i +: 4] = t[3:0];
      dch[i+1]       = t[4];
    end

    if (dec) begin
      raw_c = wide ? dch[NDIG] : dch[NNDIG];
      raw_h = dch[1];
      raw_r = dres;
    end else begin
      raw_c = wide ? bsum[DW] : bsum[NW];
      raw_h = nib[4];
      raw_r = bsum[DW-1:0];
    end

    res   = wide ? raw_r : (raw_r & NMASK);
    c_out = sub ? ~raw_c : raw_c;
    h_out = sub ? ~raw_h : raw_h;
  end

endmodule

// File: rtl/dec_alu_mul.sv
module dec_alu_mul #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dec,
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [2*BW-1:0] prod
);
  localparam int PW = 2 * BW;
  localparam int PDIG = PW / 4;

  logic [PW-1:0] acc, mcand, s1, s2;
  logic [BW-1:0] mplier;
  logic [3:0]    hi_cnt, lo_cnt;
  logic          ph_lo, dec_q;

  function automatic logic [PW-1:0] bcd_add(logic [PW-1:0] x, logic [PW-1:0] y);
    logic [PW-1:0] r;
    logic          c;
    logic [4:0]    t;
    c = 1'b0;
    r = '0;
    for (int i = 0; i < PDIG; i++) begin
      t = dec_alu_pkg::bcd_digit_add(x[4*i +: 4], y[4*i +: 4], c);
      r[4*i +: 4] = t[3:0];
      c = t[4];
    end
    return r;
  endfunction

  // two chained decimal adders: up to two units of the current digit per cycle
  assign s1 = bcd_add(acc, mcand);
  assign s2 = bcd_add(s1, mcand);
  assign prod = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      hi_cnt <= '0;
      lo_cnt <= '0;
      ph_lo  <= 1'b0;
      dec_q  <= 1'b0;
    end else if (load) begin
      acc    <= '0;
      mcand  <= {{BW{1'b0}}, a};
      mplier <= b;
      hi_cnt <= b[7:4];
      lo_cnt <= b[3:0];
      ph_lo  <= (b[7:4] == 4'd0);
      dec_q  <= dec;
    end else if (dec_q) begin
      if (!ph_lo) begin
        if (hi_cnt >= 4'd2) begin
          acc    <= (hi_cnt == 4'd2) ? {s2[PW-5:0], 4'b0} : s2;
          hi_cnt <= hi_cnt - 4'd2;
          ph_lo  <= (hi_cnt == 4'd2);
        end else begin
          acc    <= {s1[PW-5:0], 4'b0};
          hi_cnt <= 4'd0;
          ph_lo  <= 1'b1;
        end
      end else if (lo_cnt >= 4'd2) begin
        acc    <= s2;
        lo_cnt <= lo_cnt - 4'd2;
      end else if (lo_cnt == 4'd1) begin
        acc    <= s1;
        lo_cnt <= 4'd0;
      end
    end else begin
      if (mplier[0]) acc <= acc + mcand;
      mcand  <= {mcand[PW-2:0], 1'b0};
      mplier <= {1'b0, mplier[BW-1:1]};
    end
  end

  // R9
  dec_count_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (hi_cnt <= $past(hi_cnt)) && (lo_cnt <= $past(lo_cnt)));
  // R9
  dec_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_q && ph_lo && lo_cnt == 4'd0 && !load) |=> $stable(acc));

endmodule

// File: rtl/dec_alu.sv
module dec_alu
  import dec_alu_pkg::*;
#(
  parameter int DW          = 16,
  parameter int NW          = 8,
  parameter int BIN_MUL_LAT = 12,
  parameter int DEC_MUL_LAT = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [1:0]    dest,
  input  logic          imm,
  input  logic          dec_mode,
  input  logic          carry_in,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_h
);
  localparam int CW = $clog2(DEC_MUL_LAT + 1);
  localparam logic [CW-1:0] LAT_BIN_MUL = CW'(BIN_MUL_LAT);
  localparam logic [CW-1:0] LAT_DEC_MUL = CW'(DEC_MUL_LAT);
  localparam logic [CW-1:0] LAT_ONE     = CW'(1);
  localparam logic [CW-1:0] LAT_TWO     = CW'(2);

  alu_op_e  op_in, op_q;
  alu_dst_e dst_in;
  logic     dec_in, mul_in, wide_in;
  logic [CW-1:0] lat_in;

  logic     accept, fin;
  logic     dec_q, wide_q, cin_q;
  logic [DW-1:0] a_q, b_q;

  logic [DW-1:0] as_a, as_b, as_res, mul_prod, next_res;
  logic     as_cin, as_sub, as_c, as_h;

  assign op_in   = alu_op_e'(op);
  assign dst_in  = alu_dst_e'(dest);
  assign dec_in  = dec_mode && (dst_in != DST_OTHR);
  assign mul_in  = (op_in == OP_MUL);
  assign wide_in = mul_in || (dst_in == DST_PAIR) || (dst_in == DST_OTHR);

  always_comb begin
    if (mul_in)              lat_in = dec_in ? LAT_DEC_MUL : LAT_BIN_MUL;
    else if (dec_in && imm)  lat_in = LAT_TWO;
    else                     lat_in = LAT_ONE;
  end

  dec_alu_seq #(.CW(CW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .lat    (lat_in),
    .busy   (busy),
    .done   (done),
    .accept (accept),
    .fin    (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_ADD;
      dec_q  <= 1'b0;
      wide_q <= 1'b0;
      cin_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (accept) begin
      op_q   <= op_in;
      dec_q  <= dec_in;
      wide_q <= wide_in;
      cin_q  <= carry_in;
      a_q    <= opa;
      b_q    <= opb;
    end
  end

  always_comb begin
    as_sub = (op_q == OP_SUB) || (op_q == OP_SBC) || (op_q == OP_NEG);
    as_cin = ((op_q == OP_ADC) || (op_q == OP_SBC)) ? cin_q : 1'b0;
    as_a   = (op_q == OP_NEG) ? '0  : a_q;
    as_b   = (op_q == OP_NEG) ? a_q : b_q;
  end

  dec_alu_addsub #(.DW(DW), .NW(NW)) u_addsub (
    .a     (as_a),
    .b     (as_b),
    .cin   (as_cin),
    .sub   (as_sub),
    .dec   (dec_q),
    .wide  (wide_q),
    .res   (as_res),
    .c_out (as_c),
    .h_out (as_h)
  );

  dec_alu_mul #(.BW(NW)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .load (accept && mul_in),
    .dec  (dec_in),
    .a    (opa[NW-1:0]),
    .b    (opb[NW-1:0]),
    .prod (mul_prod)
  );

  assign next_res = (op_q == OP_MUL) ? mul_prod : as_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_h <= 1'b0;
    end else if (fin) begin
      result <= next_res;
      flag_c <= (op_q == OP_MUL) ? 1'b0 : as_c;
      flag_h <= (op_q == OP_MUL) ? 1'b0 : as_h;
      flag_z <= (next_res == '0);
      flag_n <= wide_q ? next_res[DW-1] : next_res[NW-1];
    end
  end

  // R10
  operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)));
  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !wide_q) |-> (result[DW-1:NW] == '0));
  // R5
  other_binary_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && dest == 2'd3) |=> !dec_q);

endmodule

// File: tb/test_dec_alu.sv
`timescale 1ns/1ps
module test_dec_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [1:0] dest = 2'd0;
  logic imm = 1'b0, dec_mode = 1'b0, carry_in = 1'b0;
  logic [15:0] opa = 16'h0, opb = 16'h0;
  logic busy, done, flag_c, flag_z, flag_n, flag_h;
  logic [15:0] result;

  dec_alu i_dec_alu (
    .clk(clk), .rst(rst), .start(start), .op(op), .dest(dest), .imm(imm),
    .dec_mode(dec_mode), .carry_in(carry_in), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit armed = 0, finished = 0;
  string ph = "R12";

  bit m_busy, m_done, m_c, m_z, m_n, m_h;
  int m_rem;
  logic [15:0] m_res;
  string m_tag = "R12", m_ltag = "R12";

  bit p_c, p_z, p_n, p_h;
  int p_lat;
  logic [15:0] p_res;
  string p_tag, p_ltag;

  function automatic int bcd_to_int(logic [15:0] v, int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] int_to_bcd(int n, int nd);
    logic [15:0] r = 16'h0;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  task automatic predict(int o, int d, bit dm, bit im, bit ci_in, logic [15:0] a, logic [15:0] b);
    int w, nd, modv, x, y, r, ci;
    bit de, sb;
    logic [15:0] xv, yv;
    if (o >= 6) o = 0;
    de = dm && (d != 3);
    w  = (d >= 2 || o == 5) ? 16 : 8;
    if (o == 5) begin
      if (de) begin
        p_res = int_to_bcd(bcd_to_int({8'h0, a[7:0]}, 2) * bcd_to_int({8'h0, b[7:0]}, 2), 4);
        p_lat = 17; p_tag = "R9";
      end else begin
        p_res = 16'(int'(a[7:0]) * int'(b[7:0]));
        p_lat = 12; p_tag = (dm && d == 3) ? "R5" : "R8";
      end
      p_c = 0; p_h = 0; p_ltag = p_tag;
    end else begin
      sb = (o == 2 || o == 3 || o == 4);
      ci = (o == 1 || o == 3) ? int'(ci_in) : 0;
      xv = (o == 4) ? 16'h0 : a;
      yv = (o == 4) ? a : b;
      if (w == 8) begin xv[15:8] = 8'h0; yv[15:8] = 8'h0; end
      if (de) begin
        nd = w / 4; modv = (nd == 2) ? 100 : 10000;
        x = bcd_to_int(xv, nd); y = bcd_to_int(yv, nd);
        if (!sb) begin
          r = x + y + ci; p_c = (r >= modv); r = r % modv;
          p_h = (int'(xv[3:0]) + int'(yv[3:0]) + ci) > 9;
        end else begin
          r = x - y - ci; p_c = (r < 0); if (r < 0) r = r + modv;
          p_h = int'(xv[3:0]) < (int'(yv[3:0]) + ci);
        end
        p_res = int_to_bcd(r, nd);
        p_tag = (o == 4) ? "R4" : (sb ? "R3" : "R2");
      end else begin
        modv = (w == 8) ? 256 : 65536;
        x = int'(xv); y = int'(yv);
        if (!sb) begin
          r = x + y + ci; p_c = (r >= modv); r = r % modv;
          p_h = (int'(xv[3:0]) + int'(yv[3:0]) + ci) > 15;
        end else begin
          r = x - y - ci; p_c = (r < 0); if (r < 0) r = r + modv;
          p_h = int'(xv[3:0]) < (int'(yv[3:0]) + ci);
        end
        p_res = 16'(r);
        p_tag = (dm && d == 3) ? "R5" : ((w == 8) ? "R6" : "R1");
      end
      p_lat = (de && im) ? 2 : 1;
      p_ltag = "R7";
    end
    p_z = (p_res == 16'h0);
    p_n = (w == 8) ? p_res[7] : p_res[15];
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = 16'h0;
      m_c = 0; m_z = 0; m_n = 0; m_h = 0; m_rem = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_busy = 0; m_done = 1; m_res = p_res;
          m_c = p_c; m_z = p_z; m_n = p_n; m_h = p_h; m_tag = p_tag;
        end
      end else if (start) begin
        predict(int'(op), int'(dest), dec_mode, imm, carry_in, opa, opb);
        m_busy = 1; m_rem = p_lat; m_ltag = p_ltag;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      checks++;
      if (busy !== m_busy || done !== m_done) begin
        errors++;
        $display("FAIL %s handshake: busy=%0b done=%0b expected busy=%0b done=%0b",
                 (ph != "") ? ph : m_ltag, busy, done, m_busy, m_done);
      end
      checks++;
      if ({result, flag_c, flag_z, flag_n, flag_h} !== {m_res, m_c, m_z, m_n, m_h}) begin
        errors++;
        $display("FAIL %s data: res=%h czn h=%b%b%b%b expected res=%h czn h=%b%b%b%b",
                 (ph != "") ? ph : (m_done ? m_tag : "R11"),
                 result, flag_c, flag_z, flag_n, flag_h, m_res, m_c, m_z, m_n, m_h);
      end
    end
  end

  function automatic logic [15:0] rand_bcd();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  task automatic issue(int o, int d, bit dm, bit im, bit ci, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    op = 3'(o); dest = 2'(d); dec_mode = dm; imm = im; carry_in = ci;
    opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: operands wander while no start is given
    for (int k = 0; k < 20; k++) begin
      opa = 16'($urandom); opb = 16'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; ph = "R12";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    ph = "";
    // R1 / R6 binary
    issue(0, 0, 0, 0, 0, 16'h007F, 16'h0001);
    issue(1, 1, 0, 0, 1, 16'h00FF, 16'h0000);
    issue(2, 2, 0, 0, 0, 16'h1000, 16'h0001);
    issue(3, 3, 0, 1, 1, 16'h0000, 16'h0000);
    issue(4, 0, 0, 0, 0, 16'h0001, 16'h0000);
    issue(6, 2, 0, 0, 0, 16'h1234, 16'h4321);
    // R2 decimal add, immediate takes the extra cycle (R7)
    issue(0, 0, 1, 1, 0, 16'h0045, 16'h0055);
    issue(1, 2, 1, 0, 1, 16'h9999, 16'h0000);
    issue(0, 1, 1, 0, 0, 16'h0019, 16'h0028);
    // R3 decimal subtract
    issue(2, 0, 1, 0, 0, 16'h0010, 16'h0001);
    issue(3, 2, 1, 1, 0, 16'h0000, 16'h0001);
    issue(3, 1, 1, 0, 1, 16'h0050, 16'h0050);
    // R4 decimal negate
    issue(4, 1, 1, 0, 0, 16'h0001, 16'h0000);
    issue(4, 0, 1, 1, 0, 16'h0000, 16'h0000);
    issue(4, 2, 1, 0, 0, 16'h0250, 16'h0000);
    // R5 other destination stays binary
    issue(0, 3, 1, 1, 0, 16'h0009, 16'h0001);
    issue(5, 3, 1, 0, 0, 16'h0099, 16'h0099);
    // R8 binary multiply
    issue(5, 2, 0, 0, 0, 16'h00FF, 16'h00FF);
    issue(5, 0, 0, 0, 0, 16'h0000, 16'h0033);
    // R9 decimal multiply
    issue(5, 2, 1, 0, 0, 16'h0099, 16'h0099);
    issue(5, 0, 1, 0, 0, 16'h0012, 16'h0034);
    issue(5, 1, 1, 0, 0, 16'h0000, 16'h0057);
    issue(5, 2, 1, 0, 0, 16'h0057, 16'h0010);
    issue(5, 2, 1, 0, 0, 16'h0099, 16'h0001);
    // R10 start during busy is ignored
    ph = "R10";
    @(negedge clk);
    op = 3'd5; dest = 2'd2; dec_mode = 1'b1; imm = 1'b0; opa = 16'h0012; opb = 16'h0034; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 3'd0; dest = 2'd0; opa = 16'h0011; opb = 16'h0022; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (11) @(negedge clk);
    op = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    ph = "";
    // mixed patterns covering R1..R9
    for (int n = 0; n < 60; n++) begin
      int o, d;
      bit dm;
      o = int'($urandom_range(0, 7)); d = int'($urandom_range(0, 3)); dm = 1'($urandom_range(0, 1));
      if (dm) issue(o, d, dm, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rand_bcd(), rand_bcd());
      else    issue(o, d, dm, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R11 watchdog: run still active, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule